// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage register with two ways in. A whole byte can be loaded from a set of parallel inputs, or the register can take one bit per rising clock edge from a single serial input. A single mode-control level chooses between the two. Data always moves from stage 1 toward stage 8. Stage 8 drives the serial output, and stages 6 and 7 are also brought out as early taps. A receiver can therefore see the next two bits before they reach the end.

A compile-time parameter picks how the parallel load is timed. In the asynchronous variant, raising the mode control loads the register at once, and the clock is ignored while the control stays high. In the synchronous variant, the load takes place on the next rising clock edge. To build a longer register, the serial output of one instance drives the serial input of the next, and all instances share the clock and the mode control.

The block has no reset. Its contents are undefined until the first load, or until eight shifts have taken place. The block never stalls: every clock edge shifts or loads, so there is no back-pressure and no handshake. A consumer that needs to pause must gate the clock edges it issues.

Top module: `piso_tap_reg`

## Requirements
- R1: While `mode_ld` is low at a rising edge of `clk`, each stage k+1 takes the previous value of stage k, and stage 1 takes `ser_in`.
- R2: In the asynchronous variant (`ASYNC_LD`=1), a rising `mode_ld` copies `par_in` into the stages before any clock edge. `par_in[i]` goes to stage i+1.
- R3: In the asynchronous variant, clock edges do not shift the register while `mode_ld` stays high. The contents stay equal to `par_in`, which the user holds stable during that time.
- R4: In the synchronous variant (`ASYNC_LD`=0), the stages do not change when `mode_ld` rises. At the next rising edge they take `par_in`, and on that edge the load wins over the shift.
- R5: `tap_m2` shows stage 6, `tap_m1` shows stage 7 and `ser_out` shows stage 8. Right after a load, `ser_out`=`par_in[7]`, `tap_m1`=`par_in[6]` and `tap_m2`=`par_in[5]`, before any shift.
- R6: In the asynchronous variant, releasing `mode_ld` does not change the stages. The first rising edge after the release shifts by exactly one position.
- R7: When one instance's `ser_out` drives a second instance's `ser_in`, eight shifts move the first instance's byte into the second one unchanged.
- R8: Bits entered on `ser_in` leave on `ser_out` eight rising edges later, in the order they went in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and synchronous-load clock, rising edge |
| mode_ld | input | 1 | High: parallel load; low: serial shift |
| ser_in | input | 1 | Serial data entering stage 1 |
| par_in | input | STAGES | Parallel load data, bit i to stage i+1 |
| tap_m2 | output | 1 | Stage 6 (third from the end) |
| tap_m1 | output | 1 | Stage 7 (second from the end) |
| ser_out | output | 1 | Stage 8, the serial output |

## Verification
A clock edge and an active load can fall in the same cycle. In the synchronous variant the bench raises `mode_ld` together with a `ser_in` value that would give a different result if a shift took place. It checks that the stages stay unchanged before the edge and hold `par_in` after it. In the asynchronous variant the bench lets clock edges arrive while `mode_ld` is high, confirms that the loaded byte stays put, and then checks that the first edge after the release shifts exactly once.

// File: rtl/piso_pkg.sv
package piso_pkg;
  localparam int unsigned PISO_STAGES = 8;
  localparam int unsigned PISO_TAPS   = 3;
  typedef logic [PISO_TAPS-1:0] piso_taps_t;
endpackage

// File: rtl/piso_cell.sv
module piso_cell #(
  parameter bit ASYNC_LD = 1'b1
) (
  input  logic clk,
  input  logic ld,
  input  logic shift_d,
  input  logic load_d,
  output logic q
);
  generate
    if (ASYNC_LD) begin : g_async
      always_ff @(posedge clk or posedge ld) begin
        if (ld) q <= load_d;
        else    q <= shift_d;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        q <= ld ? load_d : shift_d;
      end
    end
  endgenerate
endmodule

// File: rtl/piso_chain.sv
module piso_chain #(
  parameter int unsigned STAGES   = piso_pkg::PISO_STAGES,
  parameter bit          ASYNC_LD = 1'b1
) (
  input  logic                clk,
  input  logic                ld,
  input  logic                ser_in,
  input  logic [STAGES-1:0]   par_in,
  output piso_pkg::piso_taps_t taps
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] shift_d;

  assign shift_d = {stage_q[STAGES-2:0], ser_in};

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    piso_cell #(.ASYNC_LD(ASYNC_LD)) u_cell (
      .clk     (clk),
      .ld      (ld),
      .shift_d (shift_d[i]),
      .load_d  (par_in[i]),
      .q       (stage_q[i])
    );
  end

  // taps: {third from end, second from end, last}
  assign taps = {stage_q[LAST-2], stage_q[LAST-1], stage_q[LAST]};

  // Arms the checks once one edge has passed, so that $past has history.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1: a shift between two low-control edges moves every stage by one.
  a_r1_shift_step: assert property (@(posedge clk) disable iff (!armed)
    (!ld ##1 !ld) |-> stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_in)});

  generate
    if (ASYNC_LD) begin : g_chk_async
      // R3: the loaded byte is held at every edge seen under load.
      a_r3_hold_under_load: assert property (@(posedge clk) disable iff (!armed)
        ld |-> stage_q == par_in);
      // R6: the first edge after release shifts once.
      a_r6_release_shift: assert property (@(posedge clk) disable iff (!armed)
        ($past(ld) && !ld) ##1 !ld |->
          (stage_q[0] == $past(ser_in)) && (stage_q[LAST] == $past(stage_q[LAST-1])));
    end else begin : g_chk_sync
      // R4: load taken at the edge and wins over the shift.
      a_r4_sync_load: assert property (@(posedge clk) disable iff (!armed)
        ld |=> stage_q == $past(par_in));
    end
  endgenerate
endmodule

// File: rtl/piso_tap_reg.sv
module piso_tap_reg #(
  parameter int unsigned STAGES   = piso_pkg::PISO_STAGES,
  parameter bit          ASYNC_LD = 1'b1
) (
  input  logic              clk,
  input  logic              mode_ld,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic              tap_m2,
  output logic              tap_m1,
  output logic              ser_out
);
  piso_pkg::piso_taps_t taps;

  piso_chain #(.STAGES(STAGES), .ASYNC_LD(ASYNC_LD)) u_chain (
    .clk    (clk),
    .ld     (mode_ld),
    .ser_in (ser_in),
    .par_in (par_in),
    .taps   (taps)
  );

  assign tap_m2  = taps[2];
  assign tap_m1  = taps[1];
  assign ser_out = taps[0];
endmodule

// File: tb/sim_piso_tap_reg.sv
module sim_piso_tap_reg;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic ld, sin, ld1;
  logic [7:0] par, par1;
  logic o0_m2, o0_m1, o0_so, o1_m2, o1_m1, o1_so, o2_m2, o2_m1, o2_so;

  piso_tap_reg #(.ASYNC_LD(1'b1)) u0 (.clk(clk), .mode_ld(ld), .ser_in(sin),
    .par_in(par), .tap_m2(o0_m2), .tap_m1(o0_m1), .ser_out(o0_so));
  piso_tap_reg #(.ASYNC_LD(1'b1)) u1 (.clk(clk), .mode_ld(ld1), .ser_in(o0_so),
    .par_in(par1), .tap_m2(o1_m2), .tap_m1(o1_m1), .ser_out(o1_so));
  piso_tap_reg #(.ASYNC_LD(1'b0)) u2 (.clk(clk), .mode_ld(ld), .ser_in(sin),
    .par_in(par), .tap_m2(o2_m2), .tap_m1(o2_m1), .ser_out(o2_so));

  typedef struct { string tag; int inst; logic [2:0] exp; } item_t;
  item_t sbq[$];
  event chk_ev;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m0, m1, m2;
  bit k2 = 1'b0;

  function automatic logic [2:0] view(logic [7:0] m);
    return {m[5], m[6], m[7]};
  endfunction

  // Monitor: pops expectations and compares them with the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (sbq.size() > 0) begin
        item_t it;
        logic [2:0] act;
        it = sbq.pop_front();
        case (it.inst)
          0: act = {o0_m2, o0_m1, o0_so};
          1: act = {o1_m2, o1_m1, o1_so};
          default: act = {o2_m2, o2_m1, o2_so};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s u%0d taps act=%b exp=%b", it.tag, it.inst, act, it.exp);
        end
      end
    end
  end

  // Driver side: push expected tap values from the model.
  task automatic expect_all(input string tag);
    sbq.push_back('{tag, 0, view(m0)});
    sbq.push_back('{tag, 1, view(m1)});
    if (k2) sbq.push_back('{tag, 2, view(m2)});
    -> chk_ev;
    #1;
  endtask

  task automatic edge_step();
    logic [7:0] prev0;
    prev0 = m0;
    @(posedge clk);
    #2;
    if (!ld) m0 = {m0[6:0], sin};
    if (ld) begin m2 = par; k2 = 1'b1; end
    else m2 = {m2[6:0], sin};
    if (!ld1) m1 = {m1[6:0], prev0[7]};
  endtask

  task automatic raise_ld();
    ld = 1'b1;
    m0 = par;
    #1;
  endtask

  initial begin
    ld = 1'b0; sin = 1'b0; par = 8'h00; ld1 = 1'b0; par1 = 8'h00;
    #1;
    par = 8'hA5; par1 = 8'h00;
    ld1 = 1'b1; m1 = 8'h00;
    raise_ld();
    expect_all("R2 R5 async load before any edge");
    sin = 1'b1;
    edge_step();
    expect_all("R3 R4 edge under load");
    edge_step();
    expect_all("R3 second edge under load");
    ld = 1'b0; ld1 = 1'b0;
    #1;
    expect_all("R6 release changes nothing");
    sin = 1'b0;
    edge_step();
    expect_all("R6 first edge after release");
    for (int i = 6; i >= 0; i--) begin
      sin = 1'(8'b10110010 >> i);
      edge_step();
      expect_all("R1 serial shift");
    end
    expect_all("R7 cascade holds upstream byte");
    sin = 1'b0;
    for (int i = 0; i < 8; i++) begin
      edge_step();
      expect_all("R8 serial order out");
    end
    par = 8'h5A;
    sin = 1'b1;
    #1;
    raise_ld();
    expect_all("R4 sync waits for edge, R2 async loads");
    edge_step();
    expect_all("R4 load wins over shift");
    ld = 1'b0;
    sin = 1'b1;
    for (int i = 0; i < 3; i++) begin
      edge_step();
      expect_all("R1 shift after sync load");
    end
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 2000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule